// File: doc/BRIEF.md
# I2C Slave with Variable-Length Address Match

This block is an I2C target that behaves like a small byte-addressed EEPROM, suited to serving display identification data to a host. It watches a pair of open-drain lines, recognises START and STOP conditions, and compares the incoming 7-bit address against a configured device address. Only the upper 5, 6 or 7 bits of that address are compared, depending on a two-bit length code. When the address matches, the received address bits below the compared prefix are latched on an output, so the surrounding logic can tell which sub-address the host used.

After an acknowledged write address, the first data byte sets an internal word pointer. Each later byte is written to a local memory at that pointer, and the pointer then steps forward. After an acknowledged read address, the block sends bytes from the memory at the pointer, MSB first, and the pointer steps forward after each byte is loaded. Transmission stops when the host does not acknowledge a byte. The block never stretches the clock and never acts as a bus master.

Both lines pass through a synchronizer clocked by the system clock, and all edges are found on the synchronized copies. The SDA output is an active-high pull-down enable. External logic turns it into an open-drain driver.

Top module: `i2c_prefix_slave`

## Requirements
- R1: SDA falling while SCL is high is a START, and it restarts address reception from any state, including partway through a byte. SDA rising while SCL is high is a STOP: the block goes idle and releases SDA. A START or STOP never produces a memory write.
- R2: With prefix_len_i = 2'b00 (or 2'b11), all 7 address bits are compared. An exact match is acknowledged by pulling SDA low during the ninth clock.
- R3: With prefix_len_i = 2'b01, address bit 0 is ignored. On a match, low_bits_o becomes {1'b0, a[0]}.
- R4: With prefix_len_i = 2'b10, address bits 1:0 are ignored. On a match, low_bits_o becomes a[1:0]. For example, prefix 10100 accepts every address 10100xx.
- R5: A non-matching address is not acknowledged. All traffic that follows is ignored, with no acknowledge and no memory write, until the next START.
- R6: In a write, the first byte after the address loads the word pointer (mem_addr_o). Each later byte is written at the pointer, which then increments. Every byte is acknowledged.
- R7: In a read, bytes are sent MSB first starting at the pointer, and the pointer increments after each byte. The block changes its SDA drive only while SCL is low, apart from the release on START or STOP.
- R8: If the host answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and stays off the bus until the next START.
- R9: low_bits_o is updated only when an address matches. A mismatch leaves it unchanged.
- R10: mem_we_o is a one-cycle pulse, given exactly once for each stored byte.
- R11: After reset, SDA is released, low_bits_o is 0, the pointer is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| dev_addr_i | input | 7 | Configured device address |
| prefix_len_i | input | 2 | Compare length: 00/11 = 7 bits, 01 = 6 bits, 10 = 5 bits |
| low_bits_o | output | 2 | Latched address bits below the prefix |
| mem_addr_o | output | 8 | Word pointer / memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe, one cycle |
| mem_rdata_i | input | 8 | Read data at mem_addr_o, combinational |

## Verification
The assertions check four things on every cycle:
- SDA drive changes only while the synchronized SCL is low, or on a START or STOP.
- A STOP always releases SDA.
- Write strobes last one cycle, and the pointer steps forward after each one.
- A START never coincides with a write.

Address selection can only be shown by the bench's scenarios. The bench sweeps all 128 addresses under each of the three prefix lengths and checks both the acknowledge and the latched low bits, including that a mismatch holds the latched value. The bench scenarios also cover the byte-level behaviour: the pointer load, multi-byte writes and reads, the NACK-terminated read, the silence after a mismatch, and a START arriving mid-byte.

// File: rtl/i2c_prefix_pkg.sv
package i2c_prefix_pkg;
  localparam int ADDR_W = 7;
  localparam int LOW_W  = 2;
  localparam int BYTE_W = 8;

  localparam logic [1:0] PLEN_7 = 2'b00;
  localparam logic [1:0] PLEN_6 = 2'b01;
  localparam logic [1:0] PLEN_5 = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_e;

  function automatic logic [ADDR_W-1:0] prefix_mask(input logic [1:0] plen);
    case (plen)
      PLEN_6:  prefix_mask = 7'h7E;
      PLEN_5:  prefix_mask = 7'h7C;
      default: prefix_mask = 7'h7F;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]             raw;
  logic [LINES-1:0][STAGES-1:0] chain;
  logic [LINES-1:0]             cur, prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain[g] <= '1;
        prev[g]  <= 1'b1;
      end else begin
        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        prev[g]  <= chain[g][STAGES-1];
      end
    end
    assign cur[g] = chain[g][STAGES-1];
  end

  assign scl_o      = cur[0];
  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prev[0];
  assign scl_fall_o = ~cur[0] & prev[0];
  // SDA edge while SCL held high on both samples
  assign start_o    = cur[0] & prev[0] & prev[1] & ~cur[1];
  assign stop_o     = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/i2c_prefix_match.sv
module i2c_prefix_match
  import i2c_prefix_pkg::*;
(
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [1:0]        plen_i,
  output logic              hit_o,
  output logic [LOW_W-1:0]  low_o
);
  logic [ADDR_W-1:0] mask;

  assign mask  = prefix_mask(plen_i);
  assign hit_o = ((rx_addr_i ^ dev_addr_i) & mask) == '0;

  always_comb begin
    case (plen_i)
      PLEN_5:  low_o = rx_addr_i[1:0];
      PLEN_6:  low_o = {1'b0, rx_addr_i[0]};
      default: low_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_prefix_slave.sv
module i2c_prefix_slave
  import i2c_prefix_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [1:0]        prefix_len_i,
  output logic [LOW_W-1:0]  low_bits_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  slv_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              got;      // byte complete, or master ACK seen in ST_RD_ACK
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-2:0] tx_sr;
  logic              sda_oe;
  logic [PTR_W-1:0]  ptr;
  logic              first;
  logic              rw;
  logic [LOW_W-1:0]  low_q;
  logic              we;
  logic [BYTE_W-1:0] wdata;

  logic              hit;
  logic [LOW_W-1:0]  low_cand;

  i2c_prefix_match u_match (
    .rx_addr_i  (rx_sr[BYTE_W-1:1]),
    .dev_addr_i (dev_addr_i),
    .plen_i     (prefix_len_i),
    .hit_o      (hit),
    .low_o      (low_cand)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      got    <= 1'b0;
      rx_sr  <= '0;
      tx_sr  <= '0;
      sda_oe <= 1'b0;
      ptr    <= '0;
      first  <= 1'b0;
      rw     <= 1'b0;
      low_q  <= '0;
      we     <= 1'b0;
      wdata  <= '0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;

      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
        first  <= 1'b1;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              rx_sr <= {rx_sr[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
              got   <= (cnt == LAST_BIT);
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (hit) begin
                  sda_oe <= 1'b1;
                  rw     <= rx_sr[0];
                  low_q  <= low_cand;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
                if (first) begin
                  ptr   <= PTR_W'(rx_sr);
                  first <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  wdata <= rx_sr;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx_sr  <= mem_rdata_i[BYTE_W-2:0];
                sda_oe <= ~mem_rdata_i[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                cnt    <= cnt + 1'b1;
                sda_oe <= ~tx_sr[BYTE_W-2];
                tx_sr  <= {tx_sr[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              got <= ~sda_s;
            end else if (scl_fall) begin
              got <= 1'b0;
              if (got) begin
                tx_sr  <= mem_rdata_i[BYTE_W-2:0];
                sda_oe <= ~mem_rdata_i[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe;
  assign low_bits_o  = low_q;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = wdata;
  assign mem_we_o    = we;
endmodule

// File: rtl/i2c_prefix_slave_chk.sv
module i2c_prefix_slave_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic             mem_we_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det
);
  // R7
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R1
  start_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !mem_we_o);

  // R10
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> mem_addr_o == PTR_W'($past(mem_addr_o) + 1'b1));
endmodule

bind i2c_prefix_slave i2c_prefix_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det)
);

// File: tb/i2c_prefix_slave_tb.sv
module i2c_prefix_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [6:0] dev_addr = 7'h50;
  logic [1:0] plen = 2'b00;
  logic [1:0] low_bits;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] mem [256];

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  i2c_prefix_slave u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .dev_addr_i   (dev_addr),
    .prefix_len_i (plen),
    .low_bits_o   (low_bits),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_we_o     (mem_we),
    .mem_rdata_i  (mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  int we_count = 0;
  int drive_viol = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    we_count <= we_count + 1;
  end

  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe != oe_prev) drive_viol <= drive_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hclk();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b0; hclk(); scl_m = 1'b0; hclk();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; hclk(); scl_m = 1'b1; hclk(); sda_m = 1'b0; hclk(); scl_m = 1'b0; hclk();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hclk(); scl_m = 1'b1; hclk(); sda_m = 1'b1; hclk();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; hclk(); scl_m = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    seen = sda_line;
    repeat (HALF - HALF / 2) @(negedge clk);
    scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    logic [1:0] exp_low;
    int wc0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 1'b0, "R11", int'(sda_oe), 0);
    chk(low_bits == 2'b00, "R11", int'(low_bits), 0);
    chk(mem_we == 1'b0 && mem_addr == 8'h00, "R11", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R9: sweep every address under each prefix length
    dev_addr = 7'h55;
    exp_low = 2'b00;
    for (int p = 0; p < 3; p++) begin
      plen = 2'(p);
      for (int a = 0; a < 128; a++) begin
        logic [6:0] mask;
        logic hit;
        mask = (p == 0) ? 7'h7F : (p == 1) ? 7'h7E : 7'h7C;
        hit = ((7'(a) ^ dev_addr) & mask) == 7'h00;
        if (hit) exp_low = (p == 2) ? 2'(a & 3) : (p == 1) ? 2'(a & 1) : 2'b00;
        do_start();
        send_byte({7'(a), 1'b0}, ack);
        do_stop();
        chk(ack == hit, (p == 0) ? "R2" : (p == 1) ? "R3" : "R4", int'(ack), int'(hit));
        chk(low_bits == exp_low, "R9", int'(low_bits), int'(exp_low));
      end
    end

    // R6 R10: write with pointer load
    dev_addr = 7'h50; plen = 2'b10;
    wc0 = we_count;
    do_start();
    send_byte(8'hA4, ack); chk(ack, "R6", int'(ack), 1);
    chk(low_bits == 2'd2, "R4", int'(low_bits), 2);
    send_byte(8'h10, ack); chk(ack, "R6", int'(ack), 1);
    send_byte(8'hA5, ack); chk(ack, "R6", int'(ack), 1);
    send_byte(8'h3C, ack); chk(ack, "R6", int'(ack), 1);
    send_byte(8'hFF, ack); chk(ack, "R6", int'(ack), 1);
    do_stop();
    chk(mem[8'h10] == 8'hA5, "R6", int'(mem[8'h10]), 'hA5);
    chk(mem[8'h11] == 8'h3C, "R6", int'(mem[8'h11]), 'h3C);
    chk(mem[8'h12] == 8'hFF, "R6", int'(mem[8'h12]), 'hFF);
    chk(mem[8'h13] == 8'h00, "R6", int'(mem[8'h13]), 0);
    chk(we_count - wc0 == 3, "R10", we_count - wc0, 3);
    chk(mem_addr == 8'h13, "R6", int'(mem_addr), 'h13);

    // R7 R8: random read after pointer set, repeated start
    do_start();
    send_byte(8'hA4, ack);
    send_byte(8'h10, ack);
    do_rstart();
    send_byte(8'hA7, ack); chk(ack, "R7", int'(ack), 1);
    chk(low_bits == 2'd3, "R4", int'(low_bits), 3);
    recv_byte(1'b1, rb); chk(rb == 8'hA5, "R7", int'(rb), 'hA5);
    recv_byte(1'b1, rb); chk(rb == 8'h3C, "R7", int'(rb), 'h3C);
    recv_byte(1'b0, rb); chk(rb == 8'hFF, "R7", int'(rb), 'hFF);
    mem[8'h13] = 8'h00;
    recv_byte(1'b0, rb); chk(rb == 8'hFF, "R8", int'(rb), 'hFF);
    chk(sda_oe == 1'b0, "R8", int'(sda_oe), 0);
    do_stop();

    // R5: mismatch, then data is ignored
    wc0 = we_count;
    do_start();
    send_byte(8'hC0, ack); chk(!ack, "R5", int'(ack), 0);
    send_byte(8'h00, ack); chk(!ack, "R5", int'(ack), 0);
    send_byte(8'h77, ack); chk(!ack, "R5", int'(ack), 0);
    do_stop();
    chk(we_count == wc0, "R5", we_count - wc0, 0);
    chk(mem[8'h00] == 8'h00, "R5", int'(mem[8'h00]), 0);
    chk(low_bits == 2'd3, "R9", int'(low_bits), 3);

    // R1: START mid-byte restarts address reception
    do_start();
    begin
      logic s;
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    end
    do_rstart();
    send_byte(8'hA2, ack); chk(ack, "R1", int'(ack), 1);
    chk(low_bits == 2'd1, "R1", int'(low_bits), 1);
    do_stop();
    chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

    // R7 drive only while SCL low
    chk(drive_viol == 0, "R7", drive_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule